// File: doc/BRIEF.md
# In-Order Commit Reorder Buffer

This block keeps a circular record of instructions that have been dispatched but not yet retired. Each dispatched instruction takes the entry at the tail, and the index of that entry is handed back as its result tag. Operands that are still waiting name their producer by this tag, not by architectural register. Execution units return results by tag. A lookup port lets issue logic ask whether a given tag has its value yet, and read that value.

Instructions retire from the head, oldest first, at most one per cycle, and only after their result has arrived. A retiring instruction with a register destination drives an architectural register write. A retiring store raises a release strobe so that memory is updated only at that point. A branch that reaches the head marked as mispredicted retires, squashes every younger entry and signals a redirect. An instruction that reaches the head marked with a fault reports the fault and empties the buffer without updating any visible state, which keeps exceptions precise.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty (`empty`=1, `full`=0), `disp_ready` is 1, and no retire output (`rf_we`, `st_release`, `redirect`, `exc_valid`) is asserted.
- R2: Each accepted dispatch receives, on `disp_tag`, the current tail index. Tags run upward by one per dispatch and wrap from DEPTH-1 to 0.
- R3: With DEPTH entries held, `full` is 1 and `disp_ready` is 0. A `disp_valid` pulse while `disp_ready` is 0 creates no entry.
- R4: A writeback to an allocated tag marks it done and stores its value. The lookup port then returns `src_done`=1 and that value for the tag. A writeback to a tag with no live entry is ignored, so a later allocation of that tag starts not done.
- R5: Entries retire only from the head and in dispatch order. A done entry waits while any older entry is not done.
- R6: A retiring entry of kind ALU (`disp_kind`=0) that was dispatched with `disp_has_dest`=1 asserts `rf_we` for one cycle with its register in `rf_waddr` and its value in `rf_wdata`. An ALU entry without a destination retires with no register write. At most one entry retires per cycle.
- R7: A retiring store (`disp_kind`=1) asserts `st_release` with its tag on `cm_tag` and never `rf_we`. Stores and branches (`disp_kind`=2) never write a register, whatever `disp_has_dest` was.
- R8: A branch that reaches the head marked mispredicted retires with `redirect`=1 and its tag on `cm_tag`. Every younger entry is discarded with no retire output, the buffer is empty afterwards, and the next dispatch receives the branch tag plus one. A branch not marked mispredicted retires silently.
- R9: An entry that reaches the head marked faulting asserts `exc_valid` with its tag on `cm_tag`, writes no register, releases no store and empties the buffer. The next dispatch receives the faulting entry's tag.
- R10: A writeback in the cycle ending at clock edge E first shows on the retire outputs in the cycle after E, and never in the same cycle.
- R11: `disp_ready` is 0 in any cycle in which `redirect` or `exc_valid` is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_kind | input | 2 | 0 ALU, 1 store, 2 branch |
| disp_has_dest | input | 1 | Instruction writes a register (ALU only) |
| disp_areg | input | AREG_W | Destination architectural register |
| disp_ready | output | 1 | Dispatch can be accepted this cycle |
| disp_tag | output | TAG_W | Tag given to the dispatched instruction |
| wb_valid | input | 1 | Result writeback strobe |
| wb_tag | input | TAG_W | Tag being written back |
| wb_value | input | DATA_W | Result value |
| wb_exc | input | 1 | Instruction faulted |
| wb_mispred | input | 1 | Branch resolved as mispredicted |
| src_tag | input | TAG_W | Tag queried by a waiting operand |
| src_done | output | 1 | Queried tag holds a live, done entry |
| src_value | output | DATA_W | Value of the queried entry |
| rf_we | output | 1 | Architectural register write at retire |
| rf_waddr | output | AREG_W | Register written |
| rf_wdata | output | DATA_W | Data written |
| st_release | output | 1 | Store at head may update memory |
| redirect | output | 1 | Mispredicted branch retired, younger entries dropped |
| exc_valid | output | 1 | Faulting entry reached head |
| cm_tag | output | TAG_W | Tag of the entry at the head |
| full | output | 1 | All entries in use |
| empty | output | 1 | No entries in use |

## Verification
The bench returns results out of order so that younger entries finish first, which would expose a design that retires any done entry instead of waiting for the head. It fills the buffer across the index wrap and pushes a dispatch against the full flag. A design that accepted it would never drain back to empty. It also sends a writeback to a free slot and then reallocates that slot. A design that kept the stale done bit would report the new entry as ready at once. Squash tests place done younger entries behind a mispredicted branch and behind a faulting entry. Any leaked register write shows up as an extra retire event, and a tail restored to the wrong place shows up as a wrong tag on the next dispatch.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [1:0] {
        KIND_ALU    = 2'd0,
        KIND_STORE  = 2'd1,
        KIND_BRANCH = 2'd2
    } rob_kind_e;

    typedef struct packed {
        logic      busy;
        logic      done;
        rob_kind_e kind;
        logic      has_dest;
        logic      exc;
        logic      mispred;
    } rob_flags_t;

endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
    parameter int DEPTH = 8,
    localparam int TAG_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             squash_young,
    input  logic             squash_all,
    output logic [TAG_W-1:0] head,
    output logic [TAG_W-1:0] tail,
    output logic             full,
    output logic             empty
);
    typedef struct packed {
        logic [TAG_W-1:0] head;
        logic [TAG_W-1:0] tail;
        logic [CNT_W-1:0] count;
    } ptr_t;

    ptr_t st_d, st_q;

    function automatic logic [TAG_W-1:0] step(input logic [TAG_W-1:0] p);
        if (p == TAG_W'(DEPTH - 1)) return '0;
        return p + TAG_W'(1);
    endfunction

    always_comb begin
        st_d = st_q;
        if (squash_all) begin
            st_d.tail  = st_q.head;
            st_d.count = '0;
        end else if (squash_young) begin
            st_d.head  = step(st_q.head);
            st_d.tail  = step(st_q.head);
            st_d.count = '0;
        end else begin
            if (push) st_d.tail = step(st_q.tail);
            if (pop)  st_d.head = step(st_q.head);
            st_d.count = st_q.count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign head  = st_q.head;
    assign tail  = st_q.tail;
    assign full  = (st_q.count == CNT_W'(DEPTH));
    assign empty = (st_q.count == '0);

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> st_q.count != CNT_W'(DEPTH)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> st_q.count != '0); // R5

endmodule

// File: rtl/rob_entry_array.sv
module rob_entry_array
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int AREG_W = 5,
    parameter int DATA_W = 32,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [TAG_W-1:0]  alloc_idx,
    input  rob_kind_e         alloc_kind,
    input  logic              alloc_has_dest,
    input  logic [AREG_W-1:0] alloc_areg,
    input  logic              wb_en,
    input  logic [TAG_W-1:0]  wb_idx,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_exc,
    input  logic              wb_mispred,
    input  logic              free_en,
    input  logic [TAG_W-1:0]  free_idx,
    input  logic              clear_all,
    input  logic [TAG_W-1:0]  head_idx,
    output rob_flags_t        head_flags,
    output logic [AREG_W-1:0] head_areg,
    output logic [DATA_W-1:0] head_value,
    input  logic [TAG_W-1:0]  src_idx,
    output logic              src_done,
    output logic [DATA_W-1:0] src_value
);
    typedef struct packed {
        rob_flags_t        f;
        logic [AREG_W-1:0] areg;
        logic [DATA_W-1:0] val;
    } slot_t;

    slot_t slots_d [DEPTH];
    slot_t slots_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            slots_d[i] = slots_q[i];
            if (clear_all) begin
                slots_d[i].f.busy = 1'b0;
            end else begin
                if (free_en && free_idx == TAG_W'(i))
                    slots_d[i].f.busy = 1'b0;
                if (wb_en && wb_idx == TAG_W'(i) && slots_q[i].f.busy) begin
                    slots_d[i].f.done    = 1'b1;
                    slots_d[i].f.exc     = wb_exc;
                    slots_d[i].f.mispred = wb_mispred;
                    slots_d[i].val       = wb_value;
                end
                if (alloc_en && alloc_idx == TAG_W'(i)) begin
                    slots_d[i].f          = '0;
                    slots_d[i].f.busy     = 1'b1;
                    slots_d[i].f.kind     = alloc_kind;
                    slots_d[i].f.has_dest = alloc_has_dest && (alloc_kind == KIND_ALU);
                    slots_d[i].areg       = alloc_areg;
                    slots_d[i].val        = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) slots_q[i] <= slots_d[i];
        end
    end

    assign head_flags = slots_q[head_idx].f;
    assign head_areg  = slots_q[head_idx].areg;
    assign head_value = slots_q[head_idx].val;
    assign src_done   = slots_q[src_idx].f.busy && slots_q[src_idx].f.done;
    assign src_value  = slots_q[src_idx].val;

    AST_ALLOC_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !slots_q[alloc_idx].f.busy); // R2

endmodule

// File: rtl/rob_commit_sel.sv
module rob_commit_sel
    import rob_pkg::*;
#(
    parameter int AREG_W = 5,
    parameter int DATA_W = 32,
    parameter int TAG_W  = 3
) (
    input  logic              empty,
    input  logic [TAG_W-1:0]  head_idx,
    input  rob_flags_t        head_flags,
    input  logic [AREG_W-1:0] head_areg,
    input  logic [DATA_W-1:0] head_value,
    output logic              rf_we,
    output logic [AREG_W-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              st_release,
    output logic              redirect,
    output logic              exc_valid,
    output logic [TAG_W-1:0]  cm_tag,
    output logic              pop,
    output logic              squash_young,
    output logic              squash_all
);
    logic head_ready;

    always_comb begin
        head_ready   = !empty && head_flags.busy && head_flags.done;
        rf_we        = 1'b0;
        st_release   = 1'b0;
        redirect     = 1'b0;
        exc_valid    = 1'b0;
        pop          = 1'b0;
        squash_young = 1'b0;
        squash_all   = 1'b0;
        if (head_ready) begin
            if (head_flags.exc) begin
                exc_valid  = 1'b1;
                squash_all = 1'b1;
            end else begin
                pop        = 1'b1;
                rf_we      = head_flags.has_dest;
                st_release = (head_flags.kind == KIND_STORE);
                if (head_flags.kind == KIND_BRANCH && head_flags.mispred) begin
                    redirect     = 1'b1;
                    squash_young = 1'b1;
                end
            end
        end
    end

    assign rf_waddr = head_areg;
    assign rf_wdata = head_value;
    assign cm_tag   = head_idx;

endmodule

// File: rtl/rob_core.sv
module rob_core
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int AREG_W = 5,
    parameter int DATA_W = 32,
    localparam int TAG_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid,
    input  logic [1:0]        disp_kind,
    input  logic              disp_has_dest,
    input  logic [AREG_W-1:0] disp_areg,
    output logic              disp_ready,
    output logic [TAG_W-1:0]  disp_tag,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic              wb_exc,
    input  logic              wb_mispred,
    input  logic [TAG_W-1:0]  src_tag,
    output logic              src_done,
    output logic [DATA_W-1:0] src_value,
    output logic              rf_we,
    output logic [AREG_W-1:0] rf_waddr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              st_release,
    output logic              redirect,
    output logic              exc_valid,
    output logic [TAG_W-1:0]  cm_tag,
    output logic              full,
    output logic              empty
);
    logic              alloc_en, pop, squash_young, squash_all;
    logic [TAG_W-1:0]  head, tail;
    rob_flags_t        head_flags;
    logic [AREG_W-1:0] head_areg;
    logic [DATA_W-1:0] head_value;

    assign disp_ready = !full && !redirect && !exc_valid;
    assign alloc_en   = disp_valid && disp_ready;
    assign disp_tag   = tail;

    rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk(clk), .rst_n(rst_n), .push(alloc_en), .pop(pop),
        .squash_young(squash_young), .squash_all(squash_all),
        .head(head), .tail(tail), .full(full), .empty(empty)
    );

    rob_entry_array #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W)) u_array (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(alloc_en), .alloc_idx(tail), .alloc_kind(rob_kind_e'(disp_kind)),
        .alloc_has_dest(disp_has_dest), .alloc_areg(disp_areg),
        .wb_en(wb_valid), .wb_idx(wb_tag), .wb_value(wb_value),
        .wb_exc(wb_exc), .wb_mispred(wb_mispred),
        .free_en(pop), .free_idx(head), .clear_all(squash_young || squash_all),
        .head_idx(head), .head_flags(head_flags), .head_areg(head_areg),
        .head_value(head_value),
        .src_idx(src_tag), .src_done(src_done), .src_value(src_value)
    );

    rob_commit_sel #(.AREG_W(AREG_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_commit (
        .empty(empty), .head_idx(head), .head_flags(head_flags),
        .head_areg(head_areg), .head_value(head_value),
        .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
        .st_release(st_release), .redirect(redirect), .exc_valid(exc_valid),
        .cm_tag(cm_tag), .pop(pop), .squash_young(squash_young),
        .squash_all(squash_all)
    );

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect || exc_valid) |=> empty); // R8
    AST_EXC_NO_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> !rf_we && !st_release); // R9
    AST_RETIRE_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_we || st_release) |-> head_flags.done && !empty); // R5

endmodule

// File: tb/tb_rob_core.sv
module tb_rob_core;
    localparam int DEPTH = 8, AREG_W = 5, DATA_W = 32, TAG_W = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic disp_valid = 0, disp_has_dest = 0;
    logic [1:0] disp_kind = 0;
    logic [AREG_W-1:0] disp_areg = 0;
    logic disp_ready;
    logic [TAG_W-1:0] disp_tag;
    logic wb_valid = 0, wb_exc = 0, wb_mispred = 0;
    logic [TAG_W-1:0] wb_tag = 0, src_tag = 0;
    logic [DATA_W-1:0] wb_value = 0;
    logic src_done, rf_we, st_release, redirect, exc_valid, full, empty;
    logic [DATA_W-1:0] src_value, rf_wdata;
    logic [AREG_W-1:0] rf_waddr;
    logic [TAG_W-1:0] cm_tag;

    rob_core #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W)) dut (.*);

    always #2 clk = ~clk;

    int n_chk = 0, n_bad = 0, cyc = 0, exp_tail = 0, ev_n = 0;
    int ev_type [256];
    int ev_a    [256];
    int ev_c    [256];
    logic [DATA_W-1:0] ev_d [256];
    bit ev_rdy  [256];

    always @(posedge clk) cyc <= cyc + 1;

    task automatic log_ev(input int t, input int a, input logic [DATA_W-1:0] d);
        if (ev_n < 256) begin
            ev_type[ev_n] = t; ev_a[ev_n] = a; ev_d[ev_n] = d;
            ev_c[ev_n] = cyc; ev_rdy[ev_n] = disp_ready;
            ev_n++;
        end
    endtask

    // event codes: 1 register write, 2 store release, 3 redirect, 4 exception
    always @(negedge clk) if (rst_n) begin
        if (rf_we)      log_ev(1, int'(rf_waddr), rf_wdata);
        if (st_release) log_ev(2, int'(cm_tag), '0);
        if (redirect)   log_ev(3, int'(cm_tag), '0);
        if (exc_valid)  log_ev(4, int'(cm_tag), '0);
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic dispatch(input logic [1:0] kind, input bit hd, input int areg, input string req);
        @(negedge clk);
        disp_valid = 1; disp_kind = kind; disp_has_dest = hd; disp_areg = AREG_W'(areg);
        #1;
        chk(req, "disp_ready", disp_ready, 1);
        chk(req, "disp_tag", disp_tag, exp_tail);
        @(posedge clk); #1 disp_valid = 0;
        exp_tail = (exp_tail + 1) % DEPTH;
    endtask

    task automatic wb(input int tag, input int val, input bit exc, input bit mis, output int c);
        @(negedge clk);
        c = cyc;
        wb_valid = 1; wb_tag = TAG_W'(tag); wb_value = DATA_W'(val);
        wb_exc = exc; wb_mispred = mis;
        @(posedge clk); #1 wb_valid = 0; wb_exc = 0; wb_mispred = 0;
    endtask

    task automatic wait_empty(input string req);
        int k = 0;
        @(negedge clk);
        while (!empty && k < 60) begin @(negedge clk); k++; end
        chk(req, "empty after drain", empty, 1);
    endtask

    task automatic t_reset();
        @(negedge clk); #1;
        chk("R1", "empty", empty, 1);
        chk("R1", "full", full, 0);
        chk("R1", "disp_ready", disp_ready, 1);
        chk("R1", "retire outputs", {rf_we, st_release, redirect, exc_valid}, 0);
    endtask

    task automatic t_order();
        int c, base;
        base = ev_n;
        dispatch(0, 1, 3, "R2"); dispatch(0, 1, 4, "R2"); dispatch(0, 1, 5, "R2");
        wb(2, 'h22, 0, 0, c); wb(1, 'h11, 0, 0, c);
        repeat (3) @(negedge clk);
        chk("R5", "no retire before head done", ev_n, base);
        @(negedge clk); src_tag = 2; #1;
        chk("R4", "src_done tag2", src_done, 1);
        chk("R4", "src_value tag2", src_value, 'h22);
        src_tag = 0; #1;
        chk("R4", "src_done tag0 pending", src_done, 0);
        wb(0, 'h100, 0, 0, c);
        wait_empty("R5");
        chk("R5", "retire count", ev_n - base, 3);
        chk("R5", "first areg", ev_a[base], 3);
        chk("R5", "second areg", ev_a[base+1], 4);
        chk("R5", "third areg", ev_a[base+2], 5);
        chk("R6", "first data", ev_d[base], 'h100);
        chk("R6", "third data", ev_d[base+2], 'h22);
        chk("R10", "first retire cycle", ev_c[base], c + 1);
        chk("R6", "one per cycle", ev_c[base+1], c + 2);
    endtask

    task automatic t_full();
        int c, base;
        int exp_a [7] = '{10, 11, 12, 14, 15, 16, 17};
        int exp_v [7] = '{1000, 1001, 1002, 1004, 1005, 1006, 1007};
        wb(3, 'hdead, 0, 0, c);
        for (int i = 0; i < DEPTH; i++) dispatch(0, i != 3, 10 + i, "R2");
        @(negedge clk); src_tag = 3; #1;
        chk("R3", "full", full, 1);
        chk("R3", "disp_ready", disp_ready, 0);
        chk("R4", "stale wb ignored", src_done, 0);
        disp_valid = 1; disp_kind = 0; disp_has_dest = 1; disp_areg = 31;
        @(posedge clk); #1 disp_valid = 0;
        base = ev_n;
        for (int i = 0; i < DEPTH; i++) wb((3 + i) % DEPTH, 1000 + i, 0, 0, c);
        wait_empty("R3");
        chk("R6", "writes incl. no-dest skip", ev_n - base, 7);
        for (int i = 0; i < 7; i++) begin
            chk("R6", "areg order", ev_a[base+i], exp_a[i]);
            chk("R6", "data", ev_d[base+i], exp_v[i]);
        end
    endtask

    task automatic t_store();
        int c, base;
        base = ev_n;
        dispatch(1, 1, 9, "R7"); dispatch(0, 1, 7, "R7");
        wb(4, 'h77, 0, 0, c); wb(3, 'h5, 0, 0, c);
        wait_empty("R7");
        chk("R7", "event count", ev_n - base, 2);
        chk("R7", "store event", ev_type[base], 2);
        chk("R7", "store tag", ev_a[base], 3);
        chk("R7", "alu write", ev_type[base+1], 1);
        chk("R7", "alu areg", ev_a[base+1], 7);
    endtask

    task automatic t_branch();
        int c, base;
        base = ev_n;
        dispatch(2, 1, 20, "R7"); dispatch(0, 1, 21, "R8");
        wb(6, 'h66, 0, 0, c); wb(5, 0, 0, 0, c);
        wait_empty("R8");
        chk("R8", "predicted branch events", ev_n - base, 1);
        chk("R7", "branch writes nothing", ev_a[base], 21);
        base = ev_n;
        dispatch(2, 0, 0, "R8"); dispatch(0, 1, 22, "R8"); dispatch(0, 1, 23, "R8");
        wb(0, 'h220, 0, 0, c); wb(1, 'h230, 0, 0, c); wb(7, 0, 0, 1, c);
        wait_empty("R8");
        chk("R8", "squash events", ev_n - base, 1);
        chk("R8", "redirect event", ev_type[base], 3);
        chk("R8", "redirect tag", ev_a[base], 7);
        chk("R11", "ready low at redirect", ev_rdy[base], 0);
        exp_tail = 0;
        @(negedge clk); src_tag = 0; #1;
        chk("R8", "squashed entry not live", src_done, 0);
        base = ev_n;
        dispatch(0, 1, 24, "R8");
        wb(0, 'h240, 0, 0, c);
        wait_empty("R8");
        chk("R8", "post-flush write", ev_n - base, 1);
        chk("R8", "post-flush data", ev_d[base], 'h240);
    endtask

    task automatic t_exc();
        int c, base;
        base = ev_n;
        dispatch(0, 1, 25, "R9"); dispatch(1, 0, 0, "R9");
        wb(2, 0, 0, 0, c); wb(1, 'h250, 1, 0, c);
        wait_empty("R9");
        chk("R9", "only exception event", ev_n - base, 1);
        chk("R9", "exception event", ev_type[base], 4);
        chk("R9", "exception tag", ev_a[base], 1);
        chk("R11", "ready low at exception", ev_rdy[base], 0);
        exp_tail = 1;
        base = ev_n;
        dispatch(0, 1, 26, "R9");
        wb(1, 'h260, 0, 0, c);
        wait_empty("R9");
        chk("R9", "restart write", ev_n - base, 1);
        chk("R9", "restart areg", ev_a[base], 26);
    endtask

    initial begin
        #(4 * 20000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_order();
        t_full();
        t_store();
        t_branch();
        t_exc();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule